// File: doc/BRIEF.md
# Single-Channel Paced DMA Engine

This block is one DMA channel. It moves a run of elements from a source address to a destination address. Software sets it up through a small word-indexed register file: source address, destination address, byte count, a control word, an interrupt status bit and a data holding register. For each element the engine issues one read and then one write on a simple synchronous master port. The port holds each request until it is acknowledged.

The source and the destination each have their own access width (8, 16 or 32 bits) and their own address behaviour (up, down or fixed). Transfers can be paced by peripheral request lines on the read side, the write side or both. Separate programmable idle counts can be inserted between successive reads and between successive writes. A level interrupt marks completion. It is raised only after the trailing write delay, or the next pacing request, has been seen.

The control word is fixed while a transfer is running, with one exception: its run bit can still be cleared to abort. A short recovery window follows every stop.

Top module: `dma_chan`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `bus_req` is low.
- R2: Register map, by `reg_addr`: 0 is the source address, 1 the destination address, 2 the byte count, 3 the control word, 4 the status and 5 the data holding register. Writing the control word with bit 31 set, while the channel is idle and not in recovery, loads the word and starts a transfer. Bit 31 of the control word reads 1 while the transfer runs and 0 once it has finished or been aborted. Bits 30 and 26..24 read 0.
- R3: Each element is one read of the source width followed by one write of the destination width. Width fields are control bits 18..16 (source) and 10..8 (destination), coded 000 for 8, 001 for 16 and 010 for 32 bits. `bus_size` carries 0, 1 or 2 for the active access. Read data above the source width is replaced with zeros. The destination bus model stores the low bytes of `bus_wdata`, as many as the destination width, little-endian.
- R4: After each access its address moves by that access width in bytes. Control bits 23..22 (source) and 15..14 (destination) select the direction: 00 up, 01 down, 10 or 11 unchanged. Register reads return the current addresses.
- R5: At start the byte count has its low bits cleared to a multiple of the destination width. Each write lowers it by the destination width, and the transfer ends when it reaches 0. A count that aligns to 0 completes with no bus access.
- R6: Control bits 28..27 select pacing: bit 28 paces reads and bit 27 paces writes. A paced read is requested only while the request line chosen by bits 21..19 is high. A paced write is requested only while the line chosen by bits 13..11 is high. Codes 0..3 pick `dreq[0]`..`dreq[3]`.
- R7: After a read handshake, no read is requested for the number of cycles in control bits 3..0.
- R8: After a write handshake, no write is requested for the number of cycles in control bits 7..4.
- R9: While a transfer runs, writes to registers 0, 1, 2 and 5 are ignored. Writes to the control word change nothing except that a 0 in bit 31 aborts.
- R10: Writing the control word with bit 31 clear during a transfer ends it at that clock edge. No bus request and no interrupt follow.
- R11: A control word write in either of the two cycles after the channel becomes idle is ignored. One in the third cycle is accepted.
- R12: After the last write handshake, completion waits until the write idle count has expired. With no pacing it comes exactly write-delay + 1 edges after that handshake. With write pacing it also waits for the write request line to be high again. With read pacing only, it waits for the read request line.
- R13: If control bit 29 is set, `irq` goes high at the completion edge and stays high until a write to the status register with bit 0 set. An abort does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| bus_req | output | 1 | Master access request |
| bus_we | output | 1 | 1 for a write access, 0 for a read |
| bus_size | output | 2 | Access width: 0 byte, 1 halfword, 2 word |
| bus_addr | output | 32 | Access byte address |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, sampled at the handshake edge |
| bus_ack | input | 1 | Completes the access at the edge where it is high with `bus_req` |
| dreq | input | 4 | Peripheral pacing request lines |
| irq | output | 1 | Completion interrupt level |

## Verification
All state changes land on the clock edge that sees the cause. A register write takes effect at its own edge. A handshake updates the address, count and data at that edge. An abort drops `bus_req` and the run bit at once. Completion follows the last write handshake by exactly write-delay + 1 edges when no pacing line is involved.

The bench drives inputs and samples outputs on the falling edge. It records each handshake with the cycle number of the rising edge that completes it. The read and write spacing checks use those numbers, and so does the completion-timing check.

The recovery check holds a start write across three rising edges and reads the run bit after each one. It expects 0, 0 and then 1. The pacing and lock checks read registers and `bus_req` in the cycles between the stimulus and the next event that could change them.

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int RECOVER = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        bus_req,
  output logic        bus_we,
  output logic [1:0]  bus_size,
  output logic [31:0] bus_addr,
  output logic [31:0] bus_wdata,
  input  logic [31:0] bus_rdata,
  input  logic        bus_ack,
  input  logic [3:0]  dreq,
  output logic        irq
);
  localparam logic [30:0] CFG_MASK = 31'h38FF_FFFF;
  localparam int RCW = $clog2(RECOVER + 1);

  typedef enum logic [1:0] {IDLE, RD, WR, TAIL} st_t;
  st_t st;
  logic [31:0] src_a, dst_a, cnt, data_q;
  logic [30:0] cfg;
  logic [3:0]  rd_gap, wr_gap;
  logic [RCW-1:0] rec;

  function automatic logic [2:0] nbytes(input logic [2:0] w);
    return w[1] ? 3'd4 : (w[0] ? 3'd2 : 3'd1);
  endfunction

  function automatic logic [31:0] step(input logic [31:0] a, input logic [1:0] m, input logic [2:0] b);
    case (m)
      2'b00:   return a + 32'(b);
      2'b01:   return a - 32'(b);
      default: return a;
    endcase
  endfunction

  function automatic logic pick(input logic [2:0] sel, input logic [3:0] r);
    return !sel[2] && r[sel[1:0]];
  endfunction

  logic [2:0] s_bytes, d_bytes, cur_w;
  logic src_ok, dst_ok, tail_ok, active, cfg_wr, start, abort, hs;
  logic [31:0] start_cnt, rmask;

  assign s_bytes   = nbytes(cfg[18:16]);
  assign d_bytes   = nbytes(cfg[10:8]);
  assign src_ok    = !cfg[28] || pick(cfg[21:19], dreq);
  assign dst_ok    = !cfg[27] || pick(cfg[13:11], dreq);
  assign tail_ok   = cfg[27] ? pick(cfg[13:11], dreq) : (cfg[28] ? pick(cfg[21:19], dreq) : 1'b1);
  assign active    = st != IDLE;
  assign cfg_wr    = reg_wr && reg_addr == 3'd3;
  assign start     = cfg_wr && reg_wdata[31] && !active && rec == '0;
  assign abort     = cfg_wr && !reg_wdata[31] && active;
  assign start_cnt = cnt & ~(32'(nbytes(reg_wdata[10:8])) - 32'd1);
  assign rmask     = cfg[17] ? 32'hFFFF_FFFF : (cfg[16] ? 32'h0000_FFFF : 32'h0000_00FF);

  assign bus_we    = st == WR;
  assign bus_req   = (st == RD && rd_gap == '0 && src_ok) || (st == WR && wr_gap == '0 && dst_ok);
  assign bus_addr  = bus_we ? dst_a : src_a;
  assign bus_wdata = data_q;
  assign cur_w     = bus_we ? cfg[10:8] : cfg[18:16];
  assign bus_size  = cur_w[1] ? 2'd2 : {1'b0, cur_w[0]};
  assign hs        = bus_req && bus_ack;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = src_a;
      3'd1:    reg_rdata = dst_a;
      3'd2:    reg_rdata = cnt;
      3'd3:    reg_rdata = {active, cfg};
      3'd4:    reg_rdata = {31'd0, irq};
      3'd5:    reg_rdata = data_q;
      default: reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= IDLE;
      src_a  <= '0;
      dst_a  <= '0;
      cnt    <= '0;
      data_q <= '0;
      cfg    <= '0;
      rd_gap <= '0;
      wr_gap <= '0;
      rec    <= '0;
      irq    <= 1'b0;
    end else begin
      if (rec != '0) rec <= rec - 1'b1;
      if (rd_gap != '0) rd_gap <= rd_gap - 1'b1;
      if (wr_gap != '0) wr_gap <= wr_gap - 1'b1;
      if (reg_wr && reg_addr == 3'd4 && reg_wdata[0]) irq <= 1'b0;
      if (!active) begin
        if (reg_wr) begin
          case (reg_addr)
            3'd0:    src_a  <= reg_wdata;
            3'd1:    dst_a  <= reg_wdata;
            3'd2:    cnt    <= reg_wdata;
            3'd5:    data_q <= reg_wdata;
            default: ;
          endcase
        end
        if (start) begin
          cfg    <= reg_wdata[30:0] & CFG_MASK;
          cnt    <= start_cnt;
          rd_gap <= '0;
          wr_gap <= '0;
          st     <= (start_cnt == '0) ? TAIL : RD;
        end
      end else if (abort) begin
        st  <= IDLE;
        rec <= RCW'(RECOVER);
      end else begin
        case (st)
          RD: if (hs) begin
            data_q <= bus_rdata & rmask;
            src_a  <= step(src_a, cfg[23:22], s_bytes);
            rd_gap <= cfg[3:0];
            st     <= WR;
          end
          WR: if (hs) begin
            dst_a  <= step(dst_a, cfg[15:14], d_bytes);
            cnt    <= cnt - 32'(d_bytes);
            wr_gap <= cfg[7:4];
            st     <= (cnt == 32'(d_bytes)) ? TAIL : RD;
          end
          TAIL: if (wr_gap == '0 && tail_ok) begin
            st  <= IDLE;
            rec <= RCW'(RECOVER);
            if (cfg[29]) irq <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n) !active |-> !bus_req); // R2
  AST_CNT_ALIGN: assert property (@(posedge clk) disable iff (!rst_n) active |-> (cnt & (32'(d_bytes) - 32'd1)) == '0); // R5
  AST_CNT_FALLS: assert property (@(posedge clk) disable iff (!rst_n) (hs && bus_we) |=> cnt < $past(cnt)); // R5
  AST_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (active && cfg_wr) |=> $stable(cfg)); // R9
  AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (active && reg_wr && reg_addr == 3'd3 && !reg_wdata[31]) |=> (!bus_req && !reg_rdata[31] && $stable(irq))); // R10
  AST_RECOVER_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $fell(active) |=> !active ##1 !active); // R11
  AST_IRQ_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> $fell(active)); // R13
endmodule

// File: tb/dma_chan_bench.sv
module dma_chan_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic bus_req, bus_we, bus_ack = 1'b0;
  logic [1:0] bus_size;
  logic [31:0] bus_addr, bus_wdata, bus_rdata;
  logic [3:0] dreq = '0;
  logic irq;

  logic [7:0] mem [256];
  logic [7:0] refm [256];
  int checks = 0, errors = 0, cyc = 0;
  bit ack_rand = 0, dreq_rand = 0, wd = 0;
  int last_rd, last_wr, wr_hs_cyc, done_cyc, nhs;
  logic [31:0] cur_cfg, exp_src, exp_dst;

  always #4 clk = ~clk;

  dma_chan u_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bus_req(bus_req), .bus_we(bus_we), .bus_size(bus_size),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .dreq(dreq), .irq(irq)
  );

  always_comb bus_rdata = {mem[bus_addr[7:0] + 8'd3], mem[bus_addr[7:0] + 8'd2],
                           mem[bus_addr[7:0] + 8'd1], mem[bus_addr[7:0]]};

  function automatic int bw(input logic [2:0] c);
    return c[1] ? 4 : (c[0] ? 2 : 1);
  endfunction

  function automatic logic [31:0] mstep(input logic [31:0] a, input logic [1:0] m, input int b);
    if (m == 2'b00) return a + 32'(b);
    if (m == 2'b01) return a - 32'(b);
    return a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    #1;
    if (bus_req && bus_ack) begin
      nhs++;
      chk("R3 bus_size", 32'(bus_size), bus_we ? 32'(cur_cfg[9:8]) : 32'(cur_cfg[17:16]));
      if (bus_we) begin
        for (int i = 0; i < 4; i++)
          if (i < bw(cur_cfg[10:8])) mem[8'(bus_addr + 32'(i))] = bus_wdata[8*i +: 8];
        if (cur_cfg[27]) chk("R6 write pacing line", 32'(dreq[cur_cfg[12:11]]), 1);
        if (last_wr >= 0) chk("R8 write spacing ok", 32'(cyc - last_wr >= 32'(cur_cfg[7:4]) + 1), 1);
        last_wr = cyc;
        wr_hs_cyc = cyc;
      end else begin
        if (cur_cfg[28]) chk("R6 read pacing line", 32'(dreq[cur_cfg[20:19]]), 1);
        if (last_rd >= 0) chk("R7 read spacing ok", 32'(cyc - last_rd >= 32'(cur_cfg[3:0]) + 1), 1);
        last_rd = cyc;
      end
    end
    @(posedge clk);
    @(negedge clk);
    cyc++;
    if (cyc > 150000 && !wd) begin
      wd = 1;
      errors++;
      $display("FAIL R2 watchdog: actual %0d cycles expected fewer", cyc);
    end
    if (ack_rand) bus_ack = ($urandom % 100) < 70;
    if (dreq_rand) dreq = 4'($urandom);
    #1;
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic model(input logic [31:0] sa0, input logic [31:0] da0, input logic [31:0] c, input logic [31:0] cf);
    logic [31:0] sa, da, v;
    int sb, db, n;
    sa = sa0; da = da0;
    for (int i = 0; i < 256; i++) refm[i] = mem[i];
    sb = bw(cf[18:16]); db = bw(cf[10:8]);
    n = int'(c & ~(32'(db) - 1)) / db;
    for (int e = 0; e < n; e++) begin
      v = '0;
      for (int i = 0; i < sb; i++) v[8*i +: 8] = refm[8'(sa + 32'(i))];
      for (int i = 0; i < db; i++) refm[8'(da + 32'(i))] = v[8*i +: 8];
      sa = mstep(sa, cf[23:22], sb);
      da = mstep(da, cf[15:14], db);
    end
    exp_src = sa; exp_dst = da;
  endtask

  task automatic launch(input logic [31:0] sa, input logic [31:0] da, input logic [31:0] c, input logic [31:0] cf);
    model(sa, da, c, cf);
    wr_reg(3'd0, sa);
    wr_reg(3'd1, da);
    wr_reg(3'd2, c);
    cur_cfg = cf; last_rd = -1; last_wr = -1; nhs = 0;
    wr_reg(3'd3, cf | 32'h8000_0000);
  endtask

  task automatic finish_xfer(input string tag);
    logic [31:0] r;
    int bad;
    for (int k = 0; k < 4000; k++) begin
      rd_reg(3'd3, r);
      if (!r[31] || wd) break;
      tick();
    end
    done_cyc = cyc;
    chk({tag, " R2 run bit clear"}, 32'(r[31]), 0);
    bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad++;
    chk({tag, " R3 memory image mismatches"}, 32'(bad), 0);
    rd_reg(3'd0, r); chk({tag, " R4 final source address"}, r, exp_src);
    rd_reg(3'd1, r); chk({tag, " R4 final destination address"}, r, exp_dst);
    rd_reg(3'd2, r); chk({tag, " R5 final count"}, r, 0);
    chk({tag, " R13 irq level"}, 32'(irq), 32'(cur_cfg[29]));
    wr_reg(3'd4, 32'd1);
    chk({tag, " R13 irq cleared"}, 32'(irq), 0);
    tick(); tick();
  endtask

  function automatic logic [31:0] rand_cfg();
    logic [31:0] c;
    c = '0;
    c[3:0] = 4'($urandom % 5);
    c[7:4] = 4'($urandom % 5);
    c[10:8] = 3'($urandom % 3);
    c[13:11] = 3'($urandom % 4);
    c[15:14] = 2'($urandom % 3);
    c[18:16] = 3'($urandom % 3);
    c[21:19] = 3'($urandom % 4);
    c[23:22] = 2'($urandom % 3);
    c[28:27] = 2'($urandom % 4);
    c[29] = 1'($urandom % 2);
    return c;
  endfunction

  initial begin
    logic [31:0] r, cf, sa, da;
    void'($urandom(32'd1234));
    for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
    cur_cfg = '0; last_rd = -1; last_wr = -1; nhs = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), r);
      chk("R1 register reset value", r, 0);
    end
    chk("R1 irq after reset", 32'(irq), 0);
    chk("R1 bus_req after reset", 32'(bus_req), 0);

    // R5: the count aligns to zero, so the transfer completes with no access
    launch(32'h10, 32'h90, 32'd3, 32'h2000_0200);
    finish_xfer("zero-count");
    chk("R5 no bus access", 32'(nhs), 0);

    // R12: no pacing, write delay 6, one byte
    bus_ack = 1'b1;
    launch(32'h20, 32'hA0, 32'd1, 32'h2000_0060);
    finish_xfer("wdelay");
    chk("R12 completion after write delay", 32'(done_cyc - wr_hs_cyc), 8);

    // R9: writes while the channel runs are ignored
    bus_ack = 1'b0;
    cf = 32'h0001_0100;
    launch(32'h30, 32'hB0, 32'd8, cf);
    tick(); tick();
    wr_reg(3'd0, 32'h55);
    wr_reg(3'd3, 32'h8000_0000 | rand_cfg());
    rd_reg(3'd0, r); chk("R9 source address locked", r, 32'h30);
    rd_reg(3'd3, r); chk("R9 control word locked", r, 32'h8000_0000 | cf);
    bus_ack = 1'b1;
    finish_xfer("lock");

    // R10 and R11: abort, then restart only after two cycles of recovery
    bus_ack = 1'b0;
    cf = 32'h2002_0200;
    launch(32'h14, 32'hC0, 32'd12, cf);
    tick(); tick();
    wr_reg(3'd3, cf);
    rd_reg(3'd3, r); chk("R10 run bit after abort", 32'(r[31]), 0);
    chk("R10 bus_req after abort", 32'(bus_req), 0);
    chk("R10 irq after abort", 32'(irq), 0);
    reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = cf | 32'h8000_0000;
    tick(); chk("R11 start ignored in first cycle", 32'(reg_rdata[31]), 0);
    tick(); chk("R11 start ignored in second cycle", 32'(reg_rdata[31]), 0);
    tick(); chk("R11 start accepted in third cycle", 32'(reg_rdata[31]), 1);
    reg_wr = 1'b0;
    last_rd = -1; last_wr = -1;
    bus_ack = 1'b1;
    finish_xfer("restart");

    // R6, R12, R13: write pacing on line 2; completion waits for the line again
    dreq = '0;
    cf = 32'h2800_1000;
    launch(32'h40, 32'hD0, 32'd1, cf);
    repeat (6) tick();
    chk("R6 write held without request", 32'(bus_req), 0);
    rd_reg(3'd3, r); chk("R6 still running", 32'(r[31]), 1);
    dreq = 4'b0100;
    tick();
    dreq = 4'b0000;
    repeat (5) tick();
    rd_reg(3'd3, r); chk("R12 waits for request after last write", 32'(r[31]), 1);
    chk("R12 no irq before request", 32'(irq), 0);
    dreq = 4'b0100;
    tick();
    rd_reg(3'd3, r); chk("R12 completes on request", 32'(r[31]), 0);
    chk("R13 irq raised at completion", 32'(irq), 1);
    finish_xfer("paced");

    // R3..R8: random transfers
    ack_rand = 1; dreq_rand = 1;
    for (int t = 0; t < 40 && !wd; t++) begin
      cf = rand_cfg();
      sa = (cf[23:22] == 2'b00) ? 32'h10 : (cf[23:22] == 2'b01) ? 32'h70 : 32'h40;
      da = (cf[15:14] == 2'b00) ? 32'h90 : (cf[15:14] == 2'b01) ? 32'hF0 : 32'hC0;
      launch(sa + 32'($urandom % 4), da + 32'($urandom % 4), 32'($urandom % 17), cf);
      finish_xfer("random");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule